// File: doc/BRIEF.md
# Enhanced DMA Transfer Mode Selection Register

This block keeps track of which high-speed DMA transfer mode a storage device interface currently runs. The command logic hands it a set-transfer-mode request. The request either asks for a numbered enhanced mode or asks to go back to the default, non-enhanced timing. The block compares an enhanced request against the fastest mode the device was built for. An acceptable request replaces the current choice. A request that is too fast is turned away and flagged. The result drives the transfer engine through a mode number, an enable flag and a one-hot select vector, so at most one enhanced mode is ever in effect.

The block also produces a constant capability bitmap that the identify-data builder can place into the words the host reads. Support for a mode implies support for every slower mode, so the bitmap is always a contiguous run of ones starting at bit 0.

Two kinds of reset act on the block. A power-on reset or a hardware reset wipes the selection and restores the default modes. A soft reset leaves the selection as it was and only clears the refusal flag.

Top module: `xfer_mode_sel`

## Requirements
- R1: When `por_n` is low at a rising clock edge, the block enters the default state at that edge: `mode_en`=0, `active_mode`=0, `sel_onehot`=0, `req_abort`=0. This overrides every other input.
- R2: When `hw_rst_n` is low at a rising clock edge, the block enters the same default state as in R1, with the same priority.
- R3: When `soft_rst_n` is low at an edge and neither hard reset is active, `mode_en` and `active_mode` keep their values and `req_abort` is cleared. A request presented in that cycle is ignored.
- R4: A request with `req_valid`=1, `req_enh`=1 and `req_mode` <= DEV_MAX_MODE is accepted. After the next edge, `mode_en`=1, `active_mode`=`req_mode` and `req_abort`=0.
- R5: A request with `req_valid`=1, `req_enh`=1 and `req_mode` > DEV_MAX_MODE is refused. After the next edge, `mode_en` and `active_mode` are unchanged and `req_abort`=1.
- R6: A request with `req_valid`=1 and `req_enh`=0 is always accepted and returns to the default modes. After the next edge, `mode_en`=0, `active_mode`=0 and `req_abort`=0, whatever `req_mode` holds.
- R7: `sel_onehot` has exactly bit `active_mode` set while `mode_en`=1, and is all zero while `mode_en`=0.
- R8: `cap_map` bit n is 1 exactly when n <= DEV_MAX_MODE, for n from 0 to 2^MODE_W-1. The bitmap does not change with reset or with requests.
- R9: In a cycle with no reset and `req_valid`=0, `mode_en`, `active_mode` and `req_abort` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| hw_rst_n | input | 1 | Hardware reset, synchronous, active low |
| soft_rst_n | input | 1 | Soft reset, synchronous, active low; keeps the selection |
| req_valid | input | 1 | A set-transfer-mode request is present this cycle |
| req_enh | input | 1 | 1 = select the enhanced mode in `req_mode`; 0 = go back to default modes |
| req_mode | input | MODE_W | Requested enhanced mode number |
| mode_en | output | 1 | An enhanced mode is active |
| active_mode | output | MODE_W | Number of the active enhanced mode (0 when none is active) |
| sel_onehot | output | 2^MODE_W | One-hot select of the active mode for the transfer engine |
| cap_map | output | 2^MODE_W | Supported-mode bitmap for the identify data |
| req_abort | output | 1 | The most recent request was refused |

## Verification
Any corruption of the stored selection appears on `mode_en`, `active_mode` and `sel_onehot` on the cycle right after the edge that caused it. It stays visible until a new request or a hard reset replaces it. A refusal that wrongly changes the mode, or a soft reset that wrongly clears it, is therefore caught by a port sample one cycle after the stimulus. A refusal flag that is wrong in either direction shows on `req_abort` in that same cycle. A wrong bound or a wrong limit on the capability map shows up as a misplaced accept/refuse boundary. It also shows up as a wrong bit in `cap_map`, which can be seen at any time.

// File: rtl/xfm_pkg.sv
// Package: shared types for the transfer mode selection register.
// Assumes: one request is handled per cycle; the request outcome is
// decided combinationally and committed at the next clock edge.
package xfm_pkg;

    // Outcome of the request seen in the current cycle
    typedef enum logic [1:0] {
        XFM_NONE    = 2'd0,  // no request present
        XFM_DEFAULT = 2'd1,  // return to default non-enhanced modes
        XFM_ACCEPT  = 2'd2,  // enhanced mode within device range
        XFM_REFUSE  = 2'd3   // enhanced mode beyond device range
    } xfm_outcome_e;

endpackage

// File: rtl/xfm_cap_gen.sv
// Module: xfm_cap_gen
// Builds the supported-mode bitmap. Every mode up to DEV_MAX_MODE is
// supported, since a faster mode implies all slower ones.
// Assumes: DEV_MAX_MODE < NUM_MODES; the output is constant.
module xfm_cap_gen #(
    parameter int NUM_MODES    = 8,
    parameter int DEV_MAX_MODE = 2
) (
    output logic [NUM_MODES-1:0] cap_map
);

    // One constant bit per mode number: set when the mode is supported
    for (genvar i = 0; i < NUM_MODES; i++) begin : g_cap
        assign cap_map[i] = (i <= DEV_MAX_MODE);
    end

endmodule

// File: rtl/xfm_req_check.sv
// Module: xfm_req_check
// Classifies an incoming set-transfer-mode request against the device's
// fastest mode. Purely combinational.
// Assumes: req_mode is valid only while req_valid is high.
module xfm_req_check
    import xfm_pkg::*;
#(
    parameter int MODE_W       = 3,
    parameter int DEV_MAX_MODE = 2
) (
    input  logic              req_valid,
    input  logic              req_enh,
    input  logic [MODE_W-1:0] req_mode,
    output xfm_outcome_e      outcome
);

    localparam logic [MODE_W-1:0] MAX_CODE = MODE_W'(DEV_MAX_MODE);

    // Decide the fate of the request present this cycle
    always_comb begin
        if (!req_valid) begin
            outcome = XFM_NONE;
        end else if (!req_enh) begin
            outcome = XFM_DEFAULT;
        end else if (req_mode <= MAX_CODE) begin
            outcome = XFM_ACCEPT;
        end else begin
            outcome = XFM_REFUSE;
        end
    end

endmodule

// File: rtl/xfm_sel_reg.sv
// Module: xfm_sel_reg
// Holds the selected enhanced mode, its enable and the refusal flag, and
// expands the selection to a one-hot vector.
// Assumes: synchronous active-low resets; hard_rst_n combines power-on and
// hardware reset and wins over soft reset, which wins over requests.
module xfm_sel_reg
    import xfm_pkg::*;
#(
    parameter int MODE_W    = 3,
    parameter int NUM_MODES = 8
) (
    input  logic                 clk,
    input  logic                 hard_rst_n,
    input  logic                 soft_rst_n,
    input  xfm_outcome_e         outcome,
    input  logic [MODE_W-1:0]    req_mode,
    output logic                 mode_en,
    output logic [MODE_W-1:0]    mode_num,
    output logic                 abort_flag,
    output logic [NUM_MODES-1:0] sel_onehot
);

    logic              en_q;
    logic [MODE_W-1:0] mode_q;
    logic              abort_q;

    // Commit the request outcome, honouring reset priority
    always_ff @(posedge clk) begin
        if (!hard_rst_n) begin
            en_q    <= 1'b0;
            mode_q  <= '0;
            abort_q <= 1'b0;
        end else if (!soft_rst_n) begin
            abort_q <= 1'b0;
        end else begin
            unique case (outcome)
                XFM_DEFAULT: begin
                    en_q    <= 1'b0;
                    mode_q  <= '0;
                    abort_q <= 1'b0;
                end
                XFM_ACCEPT: begin
                    en_q    <= 1'b1;
                    mode_q  <= req_mode;
                    abort_q <= 1'b0;
                end
                XFM_REFUSE: begin
                    abort_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Expand the stored mode to one select line per mode
    for (genvar i = 0; i < NUM_MODES; i++) begin : g_sel
        assign sel_onehot[i] = en_q && (mode_q == MODE_W'(i));
    end

    assign mode_en    = en_q;
    assign mode_num   = mode_q;
    assign abort_flag = abort_q;

    AST_REFUSE_KEEPS: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (soft_rst_n && outcome == XFM_REFUSE) |=> ($stable(mode_q) && $stable(en_q) && abort_q)); // R5
    AST_SOFT_KEEPS: assert property (@(posedge clk) disable iff (!hard_rst_n)
        !soft_rst_n |=> ($stable(mode_q) && $stable(en_q) && !abort_q)); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (soft_rst_n && outcome == XFM_NONE) |=> ($stable(mode_q) && $stable(en_q) && $stable(abort_q))); // R9
    AST_DEFAULT_CLEARS: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (soft_rst_n && outcome == XFM_DEFAULT) |=> (!en_q && mode_q == '0 && !abort_q)); // R6

endmodule

// File: rtl/xfer_mode_sel.sv
// Module: xfer_mode_sel (top)
// Transfer mode selection register: accepts set-transfer-mode requests,
// refuses modes beyond DEV_MAX_MODE, keeps one enhanced mode active and
// publishes the supported-mode bitmap.
// Assumes: all resets synchronous and active low; DEV_MAX_MODE < 2**MODE_W.
module xfer_mode_sel
    import xfm_pkg::*;
#(
    parameter int MODE_W       = 3,
    parameter int DEV_MAX_MODE = 2,
    localparam int NUM_MODES   = 1 << MODE_W
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 hw_rst_n,
    input  logic                 soft_rst_n,
    input  logic                 req_valid,
    input  logic                 req_enh,
    input  logic [MODE_W-1:0]    req_mode,
    output logic                 mode_en,
    output logic [MODE_W-1:0]    active_mode,
    output logic [NUM_MODES-1:0] sel_onehot,
    output logic [NUM_MODES-1:0] cap_map,
    output logic                 req_abort
);

    localparam logic [MODE_W-1:0] MAX_CODE = MODE_W'(DEV_MAX_MODE);

    logic         hard_rst_n;
    xfm_outcome_e outcome;

    // Power-on and hardware reset act alike on the selection
    assign hard_rst_n = por_n && hw_rst_n;

    xfm_req_check #(
        .MODE_W       (MODE_W),
        .DEV_MAX_MODE (DEV_MAX_MODE)
    ) u_check (
        .req_valid (req_valid),
        .req_enh   (req_enh),
        .req_mode  (req_mode),
        .outcome   (outcome)
    );

    xfm_sel_reg #(
        .MODE_W    (MODE_W),
        .NUM_MODES (NUM_MODES)
    ) u_sel (
        .clk        (clk),
        .hard_rst_n (hard_rst_n),
        .soft_rst_n (soft_rst_n),
        .outcome    (outcome),
        .req_mode   (req_mode),
        .mode_en    (mode_en),
        .mode_num   (active_mode),
        .abort_flag (req_abort),
        .sel_onehot (sel_onehot)
    );

    xfm_cap_gen #(
        .NUM_MODES    (NUM_MODES),
        .DEV_MAX_MODE (DEV_MAX_MODE)
    ) u_cap (
        .cap_map (cap_map)
    );

    AST_MODE_IN_RANGE: assert property (@(posedge clk) disable iff (!hard_rst_n)
        mode_en |-> (active_mode <= MAX_CODE)); // R4
    AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!hard_rst_n)
        mode_en |-> ($countones(sel_onehot) == 1 && sel_onehot[active_mode])); // R7
    AST_NONE_IDLE: assert property (@(posedge clk) disable iff (!hard_rst_n)
        !mode_en |-> (sel_onehot == '0 && active_mode == '0)); // R7
    AST_HARD_CLEARS: assert property (@(posedge clk)
        !hard_rst_n |=> (!mode_en && !req_abort && active_mode == '0)); // R1

endmodule

// File: tb/tb_xfer_mode_sel.sv
module tb_xfer_mode_sel;

    localparam int CLK_PERIOD = 10;
    localparam int MODE_W     = 3;
    localparam int MAXM       = 2;
    localparam int NM         = 1 << MODE_W;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          hw_rst_n = 1'b1;
    logic          soft_rst_n = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_enh = 1'b0;
    logic [MODE_W-1:0] req_mode = '0;
    logic          mode_en;
    logic [MODE_W-1:0] active_mode;
    logic [NM-1:0] sel_onehot;
    logic [NM-1:0] cap_map;
    logic          req_abort;

    int n_chk = 0;
    int n_bad = 0;

    // Requirement-level model
    logic          e_en = 1'b0;
    logic [MODE_W-1:0] e_mode = '0;
    logic          e_abort = 1'b0;

    xfer_mode_sel #(.MODE_W(MODE_W), .DEV_MAX_MODE(MAXM)) dut (
        .clk(clk), .por_n(por_n), .hw_rst_n(hw_rst_n), .soft_rst_n(soft_rst_n),
        .req_valid(req_valid), .req_enh(req_enh), .req_mode(req_mode),
        .mode_en(mode_en), .active_mode(active_mode), .sel_onehot(sel_onehot),
        .cap_map(cap_map), .req_abort(req_abort)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        logic [NM-1:0] e_oh;
        e_oh = e_en ? (NM'(1) << e_mode) : '0;
        chk({tag, " mode_en"}, 32'(mode_en), 32'(e_en));
        chk({tag, " active_mode"}, 32'(active_mode), 32'(e_mode));
        chk({tag, " req_abort"}, 32'(req_abort), 32'(e_abort));
        chk({"R7 sel_onehot"}, 32'(sel_onehot), 32'(e_oh));
        chk({"R8 cap_map"}, 32'(cap_map), 32'((NM'(1) << (MAXM + 1)) - 1));
    endtask

    // Drive one cycle of inputs, update model per requirements, check after the edge
    task automatic step(input logic por, input logic hw, input logic sw,
                        input logic v, input logic enh, input int m, input string tag);
        @(negedge clk);
        por_n = por; hw_rst_n = hw; soft_rst_n = sw;
        req_valid = v; req_enh = enh; req_mode = MODE_W'(m);
        @(posedge clk);
        if (!por || !hw) begin
            e_en = 0; e_mode = 0; e_abort = 0;
        end else if (!sw) begin
            e_abort = 0;
        end else if (v) begin
            if (!enh) begin
                e_en = 0; e_mode = 0; e_abort = 0;
            end else if (m <= MAXM) begin
                e_en = 1; e_mode = MODE_W'(m); e_abort = 0;
            end else begin
                e_abort = 1;
            end
        end
        #1;
        compare(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        step(0, 1, 1, 0, 0, 0, "R1 reset");
        step(1, 1, 1, 0, 0, 0, "R9 idle after reset");
        // Sweep every start state against every request
        for (int s = -1; s <= MAXM; s++) begin
            for (int e = 0; e < 2; e++) begin
                for (int m = 0; m < NM; m++) begin
                    if (s < 0) step(1, 1, 1, 1, 0, 0, "R6 to default");
                    else       step(1, 1, 1, 1, 1, s, "R4 set start");
                    if (e == 0)      step(1, 1, 1, 1, 0, m, "R6 default request");
                    else if (m <= MAXM) step(1, 1, 1, 1, 1, m, "R4 accept");
                    else             step(1, 1, 1, 1, 1, m, "R5 refuse");
                    step(1, 1, 1, 0, 1, (m + 3) % NM, "R9 hold");
                end
            end
        end
        // Soft reset keeps mode, clears abort, ignores request
        for (int s = 0; s <= MAXM; s++) begin
            step(1, 1, 1, 1, 1, s, "R4 set");
            step(1, 1, 1, 1, 1, NM - 1, "R5 refuse");
            step(1, 1, 0, 1, 1, (s + 1) % (MAXM + 1), "R3 soft reset");
            step(1, 1, 0, 1, 0, 0, "R3 soft ignores default");
            step(1, 1, 1, 0, 0, 0, "R9 after soft");
        end
        // Hardware and power-on reset from each mode, overriding requests
        for (int s = 0; s <= MAXM; s++) begin
            step(1, 1, 1, 1, 1, s, "R4 set");
            step(1, 1, 1, 1, 1, MAXM + 1, "R5 refuse");
            step(1, 0, 1, 1, 1, MAXM, "R2 hw reset");
            step(1, 1, 1, 1, 1, s, "R4 set");
            step(0, 1, 0, 1, 1, MAXM, "R1 por reset");
            step(1, 1, 1, 0, 0, 0, "R9 idle");
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule